// File: doc/BRIEF.md
# Double-Buffered Color Matrix Converter

This block applies a 3x4 affine matrix to a stream of three-channel pixels, such as RGB or YCbCr. Each output channel is the sum of three signed coefficient-by-input products plus a signed offset. The result is rounded, then clamped to the pixel range. Two complete coefficient banks are held side by side. A host register port can write either bank and reads every register back. A mode register chooses pass-through, the primary bank or the alternate bank.

A new mode never takes effect in the middle of a frame. The mode the host writes is pending until the next frame-start strobe, and only then does it become live. The pixel that arrives with that strobe is the first one to use the new mode. The live mode can be read through a debug index/data register pair. The host reads it, fills the bank that is not live, sets the pending mode to that bank, and the switch happens cleanly at the next frame. The datapath is a three-stage pipeline, and a valid flag travels with each pixel.

Top module: `color_matrix_db`

## Requirements
- R1: After reset, pix_valid_out is 0. The mode register (address 12) reads 0. The debug data register (address 14) reads 0.
- R2: Any live mode other than 4 or 5 passes the pixel through unchanged, and mode 0 is the normal pass-through value.
- R3: With live mode 4, output channel i = clamp(floor((Ci1*x0 + Ci2*x1 + Ci3*x2 + Ci4*2^FRAC + 2^(FRAC-1)) / 2^FRAC)), using bank A. Channel j occupies bits [j*PIX_W +: PIX_W]. Coefficients are signed 16-bit values with FRAC=13 fraction bits, and the offset Ci4 is a signed count of output LSBs.
- R4: With live mode 5, the same formula applies using bank B.
- R5: Rounding is half-up, as the formula above gives. Results below 0 become 0, and results above 2^PIX_W-1 become 2^PIX_W-1.
- R6: A write to the mode register changes only the pending mode. The live mode takes the pending value on a cycle with frame_start high, and that cycle's pixel already uses it. At all other times the live mode holds.
- R7: The debug index register is at address 13, bits [3:0]. When it holds 9, address 14 returns the live mode in bits [2:0]. When it holds any other value, address 14 returns 0.
- R8: Registers 0 to 5 hold bank A and registers 6 to 11 hold bank B. Register r of a bank holds coefficient 2r in bits [15:0] and coefficient 2r+1 in bits [31:16]. Coefficient k is row k/4, column k%4. Every register reads back what was last written, and mode writes keep bits [2:0].
- R9: pix_valid_out equals pix_valid_in delayed by exactly 3 clock cycles, and every valid input produces exactly one valid output.
- R10: Writing the bank that is not live during a frame does not change any output pixel of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 2*COEF_W | Register write data |
| reg_rdata | output | 2*COEF_W | Register read data, combinational from reg_addr |
| frame_start | input | 1 | Frame boundary strobe; loads the pending mode |
| pix_valid_in | input | 1 | Input pixel valid |
| pix_in | input | 3*PIX_W | Input pixel, channel 0 in the low bits |
| pix_valid_out | output | 1 | Output pixel valid |
| pix_out | output | 3*PIX_W | Output pixel |

## Verification
The mode assertions take for granted that reset is asserted before the first frame and that only one agent writes the register port. They also assume frame_start is a single-cycle strobe. The stimulus follows the host protocol: it raises frame_start only with the first pixel of a frame and writes only the bank that is not live. Mid-frame writes, whether to the idle bank or to the pending mode, are mixed into the pixel stream on purpose. The bench model decides from its own copy of the mode and coefficient state which matrix each pixel must see.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  localparam int NCH        = 3;
  localparam int NCOL       = 4;
  localparam int NCOEF      = NCH * NCOL;
  localparam int NBANK_REGS = NCOEF / 2;
  localparam int NCOEF_REGS = 2 * NBANK_REGS;

  localparam logic [2:0] MODE_BYPASS = 3'd0;
  localparam logic [2:0] MODE_BANK_A = 3'd4;
  localparam logic [2:0] MODE_BANK_B = 3'd5;

  localparam logic [3:0] ADDR_MODE     = 4'd12;
  localparam logic [3:0] ADDR_DBG_IDX  = 4'd13;
  localparam logic [3:0] ADDR_DBG_DATA = 4'd14;
  localparam logic [3:0] DBG_SEL_LIVE  = 4'd9;
endpackage

// File: rtl/cmx_regfile.sv
module cmx_regfile
  import cmx_pkg::*;
#(
  parameter int COEF_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [3:0]                addr,
  input  logic [2*COEF_W-1:0]       wdata,
  input  logic [2:0]                live_mode,
  output logic [NCOEF*COEF_W-1:0]   bank_a,
  output logic [NCOEF*COEF_W-1:0]   bank_b,
  output logic [2:0]                pend_mode,
  output logic [3:0]                dbg_idx,
  output logic [2*COEF_W-1:0]       rdata
);
  localparam int RW = 2 * COEF_W;

  logic [RW-1:0] pair_q [NCOEF_REGS];
  logic [2:0]    mode_d, mode_q;
  logic [3:0]    idx_d, idx_q;

  // coefficient pair registers, one write enable each
  for (genvar g = 0; g < NCOEF_REGS; g++) begin : g_pair
    logic hit;
    assign hit = wr_en && (addr == 4'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pair_q[g] <= '0;
      else if (hit) pair_q[g] <= wdata;
    end
    if (g < NBANK_REGS) begin : g_a
      assign bank_a[g*RW +: RW] = pair_q[g];
    end else begin : g_b
      assign bank_b[(g-NBANK_REGS)*RW +: RW] = pair_q[g];
    end
  end

  always_comb begin
    mode_d = mode_q;
    idx_d  = idx_q;
    if (wr_en && addr == ADDR_MODE)    mode_d = wdata[2:0];
    if (wr_en && addr == ADDR_DBG_IDX) idx_d  = wdata[3:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_BYPASS;
      idx_q  <= '0;
    end else begin
      mode_q <= mode_d;
      idx_q  <= idx_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCOEF_REGS; i++)
      if (addr == 4'(i)) rdata = pair_q[i];
    if (addr == ADDR_MODE)    rdata = RW'(mode_q);
    if (addr == ADDR_DBG_IDX) rdata = RW'(idx_q);
    if (addr == ADDR_DBG_DATA && idx_q == DBG_SEL_LIVE) rdata = RW'(live_mode);
  end

  assign pend_mode = mode_q;
  assign dbg_idx   = idx_q;
endmodule

// File: rtl/cmx_frame_sync.sv
module cmx_frame_sync
  import cmx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic [2:0] pend_mode,
  output logic [2:0] live_mode,
  output logic [2:0] eff_mode
);
  logic [2:0] live_d, live_q;

  // the strobe cycle already sees the mode it loads
  always_comb begin
    live_d   = frame_start ? pend_mode : live_q;
    eff_mode = live_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= MODE_BYPASS;
    else        live_q <= live_d;
  end

  assign live_mode = live_q;
endmodule

// File: rtl/cmx_datapath.sv
module cmx_datapath
  import cmx_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int COEF_W = 16,
  parameter int FRAC   = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid_i,
  input  logic [NCH*PIX_W-1:0]    pix_i,
  input  logic [2:0]              eff_mode,
  input  logic [NCOEF*COEF_W-1:0] bank_a,
  input  logic [NCOEF*COEF_W-1:0] bank_b,
  output logic                    valid_o,
  output logic [NCH*PIX_W-1:0]    pix_o
);
  localparam int XW     = PIX_W + 1;
  localparam int PROD_W = COEF_W + XW;
  localparam int OFF_W  = COEF_W + FRAC;
  localparam int SUM_W  = ((PROD_W > OFF_W) ? PROD_W : OFF_W) + 3;
  localparam int NPROD  = NCH * NCH;
  localparam logic signed [SUM_W-1:0] RND     = SUM_W'(1) << (FRAC - 1);
  localparam logic signed [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

  logic                     use_a, use_b, byp_d;
  logic [NCOEF*COEF_W-1:0]  coef_sel;
  logic signed [PROD_W-1:0] prod_d [NPROD];
  logic signed [PROD_W-1:0] prod_q [NPROD];
  logic signed [COEF_W-1:0] off_d  [NCH];
  logic signed [COEF_W-1:0] off_q  [NCH];
  logic signed [SUM_W-1:0]  sum_d  [NCH];
  logic signed [SUM_W-1:0]  sum_q  [NCH];
  logic signed [SUM_W-1:0]  shf    [NCH];
  logic [NCH*PIX_W-1:0]     res_d;
  logic [NCH*PIX_W-1:0]     pix_s1, pix_s2, pix_s3;
  logic                     v1, v2, v3, byp1, byp2;

  always_comb begin
    use_a    = (eff_mode == MODE_BANK_A);
    use_b    = (eff_mode == MODE_BANK_B);
    byp_d    = !(use_a || use_b);
    coef_sel = use_b ? bank_b : bank_a;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    for (genvar j = 0; j < NCH; j++) begin : g_term
      assign prod_d[i*NCH+j] =
        PROD_W'($signed(coef_sel[(i*NCOL+j)*COEF_W +: COEF_W])) *
        PROD_W'($signed({1'b0, pix_i[j*PIX_W +: PIX_W]}));
    end
    assign off_d[i] = coef_sel[(i*NCOL+NCOL-1)*COEF_W +: COEF_W];

    always_comb begin
      sum_d[i] = SUM_W'(prod_q[i*NCH]) + SUM_W'(prod_q[i*NCH+1]) +
                 SUM_W'(prod_q[i*NCH+2]) + (SUM_W'(off_q[i]) <<< FRAC) + RND;
    end

    always_comb begin
      shf[i] = sum_q[i] >>> FRAC;
      if (byp2)                 res_d[i*PIX_W +: PIX_W] = pix_s2[i*PIX_W +: PIX_W];
      else if (shf[i] < 0)      res_d[i*PIX_W +: PIX_W] = '0;
      else if (shf[i] > PIX_MAX) res_d[i*PIX_W +: PIX_W] = '1;
      else                      res_d[i*PIX_W +: PIX_W] = shf[i][PIX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= valid_i;
      v2 <= v1;
      v3 <= v2;
    end
  end

  // stage 1: bank select and products
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_s1 <= '0;
      byp1   <= 1'b1;
      for (int k = 0; k < NPROD; k++) prod_q[k] <= '0;
      for (int k = 0; k < NCH; k++)   off_q[k]  <= '0;
    end else if (valid_i) begin
      pix_s1 <= pix_i;
      byp1   <= byp_d;
      for (int k = 0; k < NPROD; k++) prod_q[k] <= prod_d[k];
      for (int k = 0; k < NCH; k++)   off_q[k]  <= off_d[k];
    end
  end

  // stage 2: sums with offset and rounding constant
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_s2 <= '0;
      byp2   <= 1'b1;
      for (int k = 0; k < NCH; k++) sum_q[k] <= '0;
    end else if (v1) begin
      pix_s2 <= pix_s1;
      byp2   <= byp1;
      for (int k = 0; k < NCH; k++) sum_q[k] <= sum_d[k];
    end
  end

  // stage 3: scale, clamp, output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  pix_s3 <= '0;
    else if (v2) pix_s3 <= res_d;
  end

  assign valid_o = v3;
  assign pix_o   = pix_s3;
endmodule

// File: rtl/color_matrix_db.sv
module color_matrix_db
  import cmx_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int COEF_W = 16,
  parameter int FRAC   = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr_en,
  input  logic [3:0]             reg_addr,
  input  logic [2*COEF_W-1:0]    reg_wdata,
  output logic [2*COEF_W-1:0]    reg_rdata,
  input  logic                   frame_start,
  input  logic                   pix_valid_in,
  input  logic [NCH*PIX_W-1:0]   pix_in,
  output logic                   pix_valid_out,
  output logic [NCH*PIX_W-1:0]   pix_out
);
  logic [NCOEF*COEF_W-1:0] bank_a, bank_b;
  logic [2:0]              pend_mode, live_mode, eff_mode;
  logic [3:0]              dbg_idx;

  cmx_regfile #(.COEF_W(COEF_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .live_mode (live_mode),
    .bank_a    (bank_a),
    .bank_b    (bank_b),
    .pend_mode (pend_mode),
    .dbg_idx   (dbg_idx),
    .rdata     (reg_rdata)
  );

  cmx_frame_sync u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .pend_mode   (pend_mode),
    .live_mode   (live_mode),
    .eff_mode    (eff_mode)
  );

  cmx_datapath #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC(FRAC)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (pix_valid_in),
    .pix_i    (pix_in),
    .eff_mode (eff_mode),
    .bank_a   (bank_a),
    .bank_b   (bank_b),
    .valid_o  (pix_valid_out),
    .pix_o    (pix_out)
  );
endmodule

// File: rtl/color_matrix_db_chk.sv
module color_matrix_db_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr_en,
  input logic [3:0] reg_addr,
  input logic [2:0] wr_mode,
  input logic       frame_start,
  input logic       pix_valid_in,
  input logic       pix_valid_out,
  input logic [2:0] pend_mode,
  input logic [2:0] live_mode
);
  logic [1:0] up_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 up_cnt <= 2'd0;
    else if (up_cnt != 2'd3)    up_cnt <= up_cnt + 2'd1;
  end

  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == 2'd3) |-> (pix_valid_out == $past(pix_valid_in, 3)));

  assert_mode_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (live_mode == $past(pend_mode)));

  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(live_mode));

  assert_mode_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == 4'd12) |=> (pend_mode == $past(wr_mode)));
endmodule

bind color_matrix_db color_matrix_db_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr_en     (reg_wr_en),
  .reg_addr      (reg_addr),
  .wr_mode       (reg_wdata[2:0]),
  .frame_start   (frame_start),
  .pix_valid_in  (pix_valid_in),
  .pix_valid_out (pix_valid_out),
  .pend_mode     (pend_mode),
  .live_mode     (live_mode)
);

// File: tb/tb_color_matrix_db.sv
module tb_color_matrix_db;
  localparam int PW = 4;
  localparam int CW = 16;
  localparam int FR = 13;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        frame_start;
  logic        pix_valid_in;
  logic [11:0] pix_in;
  logic        pix_valid_out;
  logic [11:0] pix_out;

  always #4 clk = ~clk;

  color_matrix_db #(.PIX_W(PW), .COEF_W(CW), .FRAC(FR)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .pix_valid_in(pix_valid_in), .pix_in(pix_in),
    .pix_valid_out(pix_valid_out), .pix_out(pix_out)
  );

  int n_chk = 0, n_fail = 0, step_no = 0, first_out = -1;
  bit armed = 0;
  int bank_a_m[12], bank_b_m[12];
  int pend_m = 0, live_m = 0;
  int exp_q[$], req_q[$];

  int a_vals[12]  = '{6144, 4096, -2048, 1, -4096, 10240, 2048, -3, 8192, 0, 4096, 0};
  int b_init[12]  = '{7, 1007, 2007, 3007, -5, -1005, 123, 456, 32767, -32768, 1, -1};
  int b_vals[12]  = '{16383, -8192, 0, 0, 0, 0, 0, 7, -32768, 1024, 12288, 5};

  function automatic logic [31:0] pack(input int lo, input int hi);
    return {16'(hi), 16'(lo)};
  endfunction

  function automatic int calc(input int bk[12], input int i, input int x0, input int x1,
                              input int x2, output bit clamped);
    int s, q;
    s = bk[i*4]*x0 + bk[i*4+1]*x1 + bk[i*4+2]*x2 + bk[i*4+3]*8192 + 4096;
    q = s >>> 13;
    clamped = 0;
    if (q < 0) begin q = 0; clamped = 1; end
    else if (q > 15) begin q = 15; clamped = 1; end
    return q;
  endfunction

  task automatic check(input bit ok, input int req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic step(input bit v, input logic [11:0] p, input bit s, input bit we,
                      input logic [3:0] a, input logic [31:0] d, input int req);
    int e, r, ev, rq;
    bit c0, c1, c2;
    @(posedge clk); #2;
    step_no++;
    if (pix_valid_out) begin
      if (armed && first_out < 0) first_out = step_no;
      if (exp_q.size() == 0) check(0, 9, int'(pix_out), -1); // R9: no extra outputs
      else begin
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(pix_out == 12'(e), r, int'(pix_out), e);
      end
    end
    if (s) live_m = pend_m;                 // R6: strobe loads pending mode
    if (v) begin
      rq = req;
      if (live_m == 4 || live_m == 5) begin
        if (live_m == 4)
          ev = calc(bank_a_m, 0, p[3:0], p[7:4], p[11:8], c0)
             | (calc(bank_a_m, 1, p[3:0], p[7:4], p[11:8], c1) << 4)
             | (calc(bank_a_m, 2, p[3:0], p[7:4], p[11:8], c2) << 8);
        else
          ev = calc(bank_b_m, 0, p[3:0], p[7:4], p[11:8], c0)
             | (calc(bank_b_m, 1, p[3:0], p[7:4], p[11:8], c1) << 4)
             | (calc(bank_b_m, 2, p[3:0], p[7:4], p[11:8], c2) << 8);
        if ((c0 || c1 || c2) && (req == 3 || req == 4)) rq = 5; // R5 clamp cases
      end else ev = int'(p);
      exp_q.push_back(ev);
      req_q.push_back(rq);
    end
    if (we) begin
      if (a == 4'd12) pend_m = int'(d[2:0]);
      else if (a < 4'd6) begin
        bank_a_m[2*a]   = int'($signed(d[15:0]));
        bank_a_m[2*a+1] = int'($signed(d[31:16]));
      end else if (a < 4'd12) begin
        bank_b_m[2*(a-6)]   = int'($signed(d[15:0]));
        bank_b_m[2*(a-6)+1] = int'($signed(d[31:16]));
      end
    end
    pix_valid_in = v;
    pix_in       = p;
    frame_start  = s;
    reg_wr_en    = we;
    reg_addr     = a;
    reg_wdata    = d;
  endtask

  task automatic idle();
    step(0, 12'h0, 0, 0, 4'd0, 32'h0, 0);
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    step(0, 12'h0, 0, 1, a, d, 0);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input int req);
    idle();
    reg_addr = a;
    #1;
    check(reg_rdata == e, req, int'(reg_rdata), int'(e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int nlat;
    rst_n = 1'b0;
    reg_wr_en = 0; reg_addr = 0; reg_wdata = 0;
    frame_start = 0; pix_valid_in = 0; pix_in = 0;
    for (int k = 0; k < 12; k++) begin bank_a_m[k] = 0; bank_b_m[k] = 0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: reset state
    check(pix_valid_out == 1'b0, 1, int'(pix_valid_out), 0);
    rd(4'd12, 32'h0, 1);
    rd(4'd14, 32'h0, 1);

    // R7: debug index 9 selects live mode, still pass-through
    wreg(4'd13, 32'd9);
    rd(4'd14, 32'h0, 7);

    // R8: program both banks and read back
    for (int r = 0; r < 6; r++) wreg(4'(r), pack(a_vals[2*r], a_vals[2*r+1]));
    for (int r = 0; r < 6; r++) wreg(4'(6+r), pack(b_init[2*r], b_init[2*r+1]));
    for (int r = 0; r < 6; r++) rd(4'(r), pack(a_vals[2*r], a_vals[2*r+1]), 8);
    for (int r = 0; r < 6; r++) rd(4'(6+r), pack(b_init[2*r], b_init[2*r+1]), 8);

    // R2: pass-through frame, exhaustive
    for (int n = 0; n < 4096; n++) step(1, 12'(n), n == 0, 0, 4'd0, 32'h0, 2);

    // R6: pending mode 4 without a strobe keeps pass-through
    wreg(4'd12, 32'd4);
    rd(4'd12, 32'd4, 8);
    rd(4'd14, 32'd0, 6);
    for (int n = 0; n < 16; n++) step(1, 12'(n*251), 0, 0, 4'd0, 32'h0, 6);

    // R3 on bank A; from pixel 100 bank B is rewritten mid-frame (R10)
    for (int n = 0; n < 4096; n++) begin
      bit we;
      int r;
      we = (n >= 100 && n < 106);
      r  = n - 100;
      if (we) step(1, 12'(n), 0, 1, 4'(6 + r), pack(b_vals[2*r], b_vals[2*r+1]), 10);
      else    step(1, 12'(n), n == 0, 0, 4'd0, 32'h0, (n < 100) ? 3 : 10);
    end
    rd(4'd14, 32'd4, 7);
    wreg(4'd13, 32'd3);
    rd(4'd14, 32'd0, 7);
    wreg(4'd13, 32'd9);

    // R4 on bank B; a mid-frame mode write must not take effect (R6)
    wreg(4'd12, 32'd5);
    for (int n = 0; n < 4096; n++) begin
      if (n == 2000) step(1, 12'(n), 0, 1, 4'd12, 32'd4, 4);
      else           step(1, 12'(n), n == 0, 0, 4'd0, 32'h0, 4);
    end
    rd(4'd14, 32'd5, 7);

    // R2: an unassigned mode value also passes through
    wreg(4'd12, 32'd7);
    for (int n = 0; n < 256; n++) step(1, 12'(n*13 + 5), n == 0, 0, 4'd0, 32'h0, 2);

    repeat (4) idle();
    check(exp_q.size() == 0, 9, exp_q.size(), 0);     // R9: one output per input

    // R9: isolated pixel appears exactly three cycles later
    armed = 1;
    first_out = -1;
    step(1, 12'h5a5, 0, 0, 4'd0, 32'h0, 9);
    nlat = step_no;
    repeat (5) idle();
    check(first_out == nlat + 3, 9, first_out - nlat, 3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule